// File: doc/BRIEF.md
# Capacitor DAC Trim Calibrator

This controller trims the four largest capacitors of a 12-bit successive-approximation converter whose capacitor DAC has thirteen switched elements (indices 12 down to 0) plus one spare unit capacitor that doubles the weight of the smallest element. Each of the four top elements (indices 9, 10, 11, 12) carries a 7-bit trim code. The controller sets the reference switches so that the element under test sits against a group of smaller elements. It then asks the comparator which side is heavier and refines that element's code one bit at a time.

The calibration is strictly sequential. Element 9 is matched against elements 8..0 plus the spare unit. Element 10 is matched against the already-trimmed element 9 plus elements 8..0 and the spare. Elements 11 and 12 use the same group as element 10. A control register pulses `start`, sets the vote count, and reads the final codes back through a select port once `done` is high.

Top module: `cdac_trim_cal`

## Requirements
- R1: After reset, `busy`, `done`, `cmp_go`, `dac_hi`, `dac_lo` and `dac_dmy_lo` are all zero, and every trim code holds midscale 7'b1000000.
- R2: A `start` pulse sets `busy` and clears `done` in the next cycle, and returns all four codes to midscale 7'b1000000 before any search begins.
- R3: Elements are calibrated in the fixed order index 9, 10, 11, 12. While calibrating element 9+k, `dac_hi` has exactly bit 9+k set.
- R4: While busy, `dac_dmy_lo` is 1. `dac_lo` is 13'h1FF (elements 8..0) when trimming element 9, and 13'h3FF (elements 9..0) when trimming elements 10, 11 and 12. `dac_hi` and `dac_lo` never share a bit.
- R5: Each code is found by a binary search from bit 6 down to bit 0, with one decision per bit. A "high" decision clears the trial bit, and a "low" decision keeps it. If the comparator reports high exactly when the code exceeds a threshold T, the final code equals T.
- R6: Each decision is a majority of N comparator trials, where N is `vote_n` latched at start and a value of 0 means one trial. The decision is high only when more than half of the trials returned `cmp_hi`=1. A tie counts as low.
- R7: The controller issues exactly 28·N `cmp_go` pulses per complete calibration. It issues each pulse only while busy, and issues a new pulse only after `cmp_rdy` answers the previous one.
- R8: `done` rises in the cycle after the last decision on element 12, at the same time as `busy` falls. The codes then stay constant until the next `start`.
- R9: `trim_rd` shows the code of the element selected by `trim_sel` (0 selects element 9, 3 selects element 12). `trim_flat` carries element 9+k's code in bits [7k+6:7k].
- R10: A `start` pulse while busy abandons the running search and restarts the whole sequence from element 9 with midscale codes.
- R11: `cmp_rdy` and `cmp_hi` have no effect when no comparator request is outstanding, for example while idle or after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle request to run (or rerun) calibration |
| vote_n | input | VOTE_W | Comparator trials per decision (0 means 1) |
| cmp_rdy | input | 1 | Comparator result valid strobe |
| cmp_hi | input | 1 | Comparator result: element under test heavier |
| trim_sel | input | 2 | Readback select, 0..3 for elements 9..12 |
| cmp_go | output | 1 | Single-cycle comparator request |
| dac_hi | output | 13 | Elements switched to the positive reference |
| dac_lo | output | 13 | Elements switched to the negative reference |
| dac_dmy_lo | output | 1 | Spare unit element switched to the negative reference |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | All four codes final |
| trim_flat | output | 4*TRIM_W | All four trim codes, element 9 in the low bits |
| trim_rd | output | TRIM_W | Code of the element chosen by trim_sel |

## Verification
The bound checker watches the switch patterns on every cycle: the disjoint positive and negative groups, the single element under test, and the order never stepping backwards within a run. It also covers requests only while busy, the midscale reload after start, and codes frozen while idle or done. What the codes converge to can only be shown by the bench scenarios, which use a comparator model whose threshold for each element depends on the code already found below it. These scenarios also cover majority voting against injected trial errors, the tie rule with two trials, the restart mid-search, and the total request count per run.

// File: rtl/cdac_trim_cal.sv
module cdac_trim_cal #(
  parameter int TRIM_W = 7,
  parameter int VOTE_W = 4,
  parameter int SETTLE = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VOTE_W-1:0]     vote_n,
  input  logic                  cmp_rdy,
  input  logic                  cmp_hi,
  input  logic [1:0]            trim_sel,
  output logic                  cmp_go,
  output logic [12:0]           dac_hi,
  output logic [12:0]           dac_lo,
  output logic                  dac_dmy_lo,
  output logic                  busy,
  output logic                  done,
  output logic [4*TRIM_W-1:0]   trim_flat,
  output logic [TRIM_W-1:0]     trim_rd
);
  localparam int NCAP    = 4;
  localparam int DAC_W   = 13;
  localparam int CAL_LSB = 9;
  localparam int BIT_W   = $clog2(TRIM_W);
  localparam int SCNT_W  = $clog2(SETTLE + 1);
  localparam int CNT_W   = VOTE_W + 1;
  localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);
  localparam logic [DAC_W-1:0] GRP_FIRST = DAC_W'((1 << CAL_LSB) - 1);
  localparam logic [DAC_W-1:0] GRP_REST  = DAC_W'((1 << (CAL_LSB + 1)) - 1);

  typedef enum logic [1:0] {S_IDLE, S_SETTLE, S_WAIT} st_t;

  st_t                         st_q;
  logic [NCAP-1:0][TRIM_W-1:0] code_q;
  logic [1:0]                  k_q;
  logic [BIT_W-1:0]            bit_q;
  logic [SCNT_W-1:0]           scnt_q;
  logic [CNT_W-1:0]            vote_q, tcnt_q, ones_q;
  logic                        go_q, busy_q, done_q;

  logic [CNT_W-1:0] ntr_in, ones_nx, tcnt_nx;
  logic             last_trial, verdict_hi;

  assign ntr_in     = (vote_n == '0) ? CNT_W'(1) : {1'b0, vote_n};
  assign ones_nx    = ones_q + CNT_W'(cmp_hi);
  assign tcnt_nx    = tcnt_q + CNT_W'(1);
  assign last_trial = (tcnt_nx == vote_q);
  assign verdict_hi = {ones_nx, 1'b0} > {1'b0, vote_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      code_q <= {NCAP{MID}};
      k_q    <= '0;
      bit_q  <= BIT_W'(TRIM_W - 1);
      scnt_q <= '0;
      vote_q <= CNT_W'(1);
      tcnt_q <= '0;
      ones_q <= '0;
      go_q   <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      st_q   <= S_SETTLE;
      code_q <= {NCAP{MID}};
      k_q    <= '0;
      bit_q  <= BIT_W'(TRIM_W - 1);
      scnt_q <= '0;
      vote_q <= ntr_in;
      tcnt_q <= '0;
      ones_q <= '0;
      go_q   <= 1'b0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      go_q <= 1'b0;
      case (st_q)
        S_SETTLE: begin
          if (scnt_q == SCNT_W'(SETTLE)) begin
            go_q <= 1'b1;
            st_q <= S_WAIT;
          end else begin
            scnt_q <= scnt_q + SCNT_W'(1);
          end
        end
        S_WAIT: begin
          if (cmp_rdy) begin
            if (!last_trial) begin
              tcnt_q <= tcnt_nx;
              ones_q <= ones_nx;
              go_q   <= 1'b1;
            end else begin
              tcnt_q <= '0;
              ones_q <= '0;
              scnt_q <= '0;
              if (verdict_hi) code_q[k_q][bit_q] <= 1'b0;
              if (bit_q != '0) begin
                code_q[k_q][bit_q - BIT_W'(1)] <= 1'b1;
                bit_q <= bit_q - BIT_W'(1);
                st_q  <= S_SETTLE;
              end else if (k_q == 2'(NCAP - 1)) begin
                st_q   <= S_IDLE;
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end else begin
                k_q   <= k_q + 2'd1;
                bit_q <= BIT_W'(TRIM_W - 1);
                st_q  <= S_SETTLE;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign cmp_go     = go_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign dac_hi     = busy_q ? (DAC_W'(1) << (CAL_LSB + int'(k_q))) : '0;
  assign dac_lo     = busy_q ? ((k_q == 2'd0) ? GRP_FIRST : GRP_REST) : '0;
  assign dac_dmy_lo = busy_q;
  assign trim_flat  = code_q;
  assign trim_rd    = code_q[trim_sel];
endmodule

// File: rtl/cdac_trim_cal_chk.sv
module cdac_trim_cal_chk #(
  parameter int TRIM_W = 7
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic                cmp_go,
  input logic [12:0]         dac_hi,
  input logic [12:0]         dac_lo,
  input logic                busy,
  input logic                done,
  input logic [4*TRIM_W-1:0] trim_flat
);
  localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

  // R4
  disjoint_groups_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_hi & dac_lo) == 13'd0);

  // R3
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($onehot0(dac_hi) && dac_hi[8:0] == 9'd0 && dac_hi != 13'd0));

  // R3
  forward_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start)) |-> dac_hi >= $past(dac_hi));

  // R7
  go_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_go |-> busy);

  // R8
  done_excl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R2
  start_midscale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && trim_flat == {4{MID}}));

  // R8
  codes_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(trim_flat));
endmodule

bind cdac_trim_cal cdac_trim_cal_chk #(.TRIM_W(TRIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cmp_go(cmp_go),
  .dac_hi(dac_hi), .dac_lo(dac_lo), .busy(busy), .done(done),
  .trim_flat(trim_flat)
);

// File: tb/cdac_trim_cal_test.sv
module cdac_trim_cal_test;
  localparam int TRIM_W = 7;
  localparam int VOTE_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [VOTE_W-1:0] vote_n = '0;
  logic cmp_rdy, cmp_hi;
  logic [1:0] trim_sel = 2'd0;
  logic cmp_go, dac_dmy_lo, busy, done;
  logic [12:0] dac_hi, dac_lo;
  logic [4*TRIM_W-1:0] trim_flat;
  logic [TRIM_W-1:0] trim_rd;

  cdac_trim_cal #(.TRIM_W(TRIM_W), .VOTE_W(VOTE_W), .SETTLE(2)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vote_n(vote_n),
    .cmp_rdy(cmp_rdy), .cmp_hi(cmp_hi), .trim_sel(trim_sel),
    .cmp_go(cmp_go), .dac_hi(dac_hi), .dac_lo(dac_lo), .dac_dmy_lo(dac_dmy_lo),
    .busy(busy), .done(done), .trim_flat(trim_flat), .trim_rd(trim_rd)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  int base [4];
  int ntr_b = 1;
  bit noise_b = 1'b0;
  bit inj = 1'b0;
  int gidx = 0;
  int go_cnt = 0;
  bit resp_pend = 1'b0;
  bit resp_val = 1'b0;

  logic [4*TRIM_W-1:0] exp_q [$];
  int exp_go_q [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int code_of(input int k);
    return int'(trim_flat[k*TRIM_W +: TRIM_W]);
  endfunction

  // Comparator model: high when the code of the element under test exceeds its threshold
  initial begin
    cmp_rdy = 1'b0;
    cmp_hi = 1'b0;
    forever begin
      @(negedge clk);
      cmp_rdy = inj;
      cmp_hi = inj;
      if (resp_pend) begin
        cmp_rdy = 1'b1;
        cmp_hi = resp_val;
        resp_pend = 1'b0;
      end
      if (cmp_go) begin
        int k, tgt;
        bit truth;
        k = go_cnt / (7 * ntr_b);
        if (k > 3) k = 3;
        // R3: element under test
        chk(dac_hi == (13'd1 << (9 + k)), "R3", "dac_hi at request", dac_hi, 13'd1 << (9 + k));
        // R4: reference group
        chk(dac_lo == ((k == 0) ? 13'h1FF : 13'h3FF) && dac_dmy_lo, "R4", "dac_lo at request",
            dac_lo, (k == 0) ? 13'h1FF : 13'h3FF);
        tgt = base[k] + ((k > 0) ? (code_of(k - 1) >> 4) : 0);
        truth = code_of(k) > tgt;
        resp_val = (noise_b && gidx == 0) ? !truth : truth;
        gidx = (gidx + 1) % ntr_b;
        go_cnt++;
        resp_pend = 1'b1;
      end
    end
  end

  // Scoreboard monitor
  initial begin
    forever begin
      @(posedge done);
      @(negedge clk);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected done", 1, 0);
      end else begin
        logic [4*TRIM_W-1:0] e;
        int eg;
        e = exp_q.pop_front();
        eg = exp_go_q.pop_front();
        // R5 R6 final codes
        chk(trim_flat == e, "R5/R6", "final codes", trim_flat, e);
        // R7 request count
        chk(go_cnt == eg, "R7", "request count", go_cnt, eg);
        // R8 busy drops with done
        chk(!busy, "R8", "busy at done", busy, 0);
      end
    end
  end

  task automatic run_cal(input int b0, input int b1, input int b2, input int b3,
                         input int votes, input bit noisy, input bit keep_all);
    int c [4];
    int ntr;
    ntr = (votes == 0) ? 1 : votes;
    c[0] = b0;
    c[1] = b1 + (c[0] >> 4);
    c[2] = b2 + (c[1] >> 4);
    c[3] = b3 + (c[2] >> 4);
    if (keep_all) for (int i = 0; i < 4; i++) c[i] = 127;
    exp_q.push_back({7'(c[3]), 7'(c[2]), 7'(c[1]), 7'(c[0])});
    exp_go_q.push_back(28 * ntr);
    do @(negedge clk); while (cmp_go);
    base[0] = b0; base[1] = b1; base[2] = b2; base[3] = b3;
    ntr_b = ntr;
    noise_b = noisy;
    gidx = 0;
    go_cnt = 0;
    vote_n = VOTE_W'(votes);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2
    chk(busy && !done && trim_flat == {4{7'h40}}, "R2", "state after start", trim_flat, {4{7'h40}});
    @(posedge done);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    wrap_up();
  end

  initial begin
    logic [4*TRIM_W-1:0] snap;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !cmp_go, "R1", "flags after reset", {busy, done, cmp_go}, 0);
    chk(dac_hi == 0 && dac_lo == 0 && !dac_dmy_lo, "R1", "switches after reset", dac_hi | dac_lo, 0);
    chk(trim_flat == {4{7'h40}}, "R1", "codes after reset", trim_flat, {4{7'h40}});
    rst_n = 1'b1;
    @(negedge clk);

    // R5: single trial, mixed thresholds
    run_cal(37, 90, 5, 112, 1, 1'b0, 1'b0);
    // R6: three trials, one wrong per decision, majority still correct
    run_cal(64, 0, 100, 12, 3, 1'b1, 1'b0);
    // R6: two trials with one wrong gives a tie, counted as low, so every bit is kept
    run_cal(20, 20, 20, 20, 2, 1'b1, 1'b1);
    // R5 R6: vote_n 0 means one trial; lower boundary codes
    run_cal(0, 0, 0, 0, 0, 1'b0, 1'b0);
    // R5: upper boundary codes
    run_cal(119, 119, 119, 119, 1, 1'b0, 1'b0);

    // R9: readback by select
    for (int s = 0; s < 4; s++) begin
      trim_sel = 2'(s);
      @(negedge clk);
      chk(trim_rd == trim_flat[s*TRIM_W +: TRIM_W], "R9", "readback", trim_rd,
          trim_flat[s*TRIM_W +: TRIM_W]);
    end
    chk(trim_flat[6:0] == 7'd119 && trim_flat[27:21] == 7'd126, "R9", "field placement",
        trim_flat, {7'd126, 7'd126, 7'd126, 7'd119});

    // R11: stray comparator strobes after done
    snap = trim_flat;
    inj = 1'b1;
    repeat (4) @(negedge clk);
    inj = 1'b0;
    repeat (2) @(negedge clk);
    chk(trim_flat == snap, "R11", "codes after stray strobes", trim_flat, snap);
    chk(done && !busy && !cmp_go, "R11", "flags after stray strobes", {done, busy}, 2'b10);
    // R8: codes held while done
    repeat (20) @(negedge clk);
    chk(trim_flat == snap && done, "R8", "codes held after done", trim_flat, snap);

    // R10: restart in the middle of a search
    base[0] = 50; base[1] = 10; base[2] = 70; base[3] = 30;
    ntr_b = 1; noise_b = 1'b0; go_cnt = 0; vote_n = VOTE_W'(1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (60) @(negedge clk);
    chk(busy && !done, "R10", "mid-run before restart", {busy, done}, 2'b10);
    run_cal(50, 10, 70, 30, 1, 1'b0, 1'b0);

    repeat (5) @(negedge clk);
    wrap_up();
  end
endmodule